// File: doc/BRIEF.md
# Two-Stage RV32I Integer Core

This block is a small 32-bit RISC-V integer core for control tasks that need about one instruction per clock and little logic. It runs the base RV32I integer instructions: register and immediate arithmetic, logic, shifts and compares, LUI and AUIPC, the six conditional branches, JAL and JALR, and byte, halfword and word loads and stores. The pipeline has two stages. The first stage sends the program counter to the instruction port. The second stage decodes the returned word, reads the register file, executes, accesses data memory and writes back, all in the same clock. The two stages overlap. The core has no interlocks and no forwarding path, because every result is written before the next instruction reads its operands.

Instructions and data sit on two separate ports (Harvard organisation). Both ports return read data in the same cycle as the address. Writes commit on a clock edge, and the byte-enable mask selects which bytes are written. A single `halt` input stretches the current access by any number of wait states. While `halt` is high the core keeps its state, and it keeps presenting the same request on both ports. A taken branch or jump throws away the one instruction already fetched behind it. Opcodes outside the supported set execute as no-operations.

Top module: `rv_duo_core`

## Requirements
- R1: While reset is low, and in the first cycle after it, `imem_addr` equals RESET_PC (default 0). The first execute slot after reset is a bubble: it asserts neither `dmem_rd` nor `dmem_wr`, whatever word sits at RESET_PC. The instruction at RESET_PC executes in the second cycle.
- R2: Register x0 always reads as zero. A write that names x0 as destination has no effect.
- R3: With `halt` low and no redirect, `imem_addr` rises by 4 every clock, and the core completes one instruction per clock. An instruction that reads a register written by the instruction just before it gets the new value.
- R4: A taken branch, JAL or JALR discards the instruction fetched behind it. That costs one bubble clock, and fetch resumes at the target.
- R5: Register and immediate ALU operations give the RV32I results: ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR, AND. This includes SLTI, SLTIU and SRAI, which is chosen by instruction bit 30 when funct3 is 101. LUI writes the immediate shifted up by 12 bits. AUIPC writes that value plus the instruction's own address.
- R6: Branches compare two registers by funct3: 000 equal, 001 not equal, 100 signed less than, 101 signed greater or equal, 110 unsigned less than, 111 unsigned greater or equal. A taken branch goes to PC plus its immediate. JAL and JALR write PC+4 to rd. JALR jumps to rs1 plus its immediate with bit 0 cleared.
- R7: Stores use little-endian byte lanes. The store size comes from funct3 (000 byte, 001 halfword, 010 word). A byte store sets the single `dmem_be` bit numbered by address bits [1:0]. A halfword store sets 0011 or 1100, chosen by address bit 1. A word store sets 1111. The store data is repeated across all lanes.
- R8: Loads take the byte or halfword at address bits [1:0] from the little-endian word. funct3 000 (byte) and 001 (halfword) sign-extend the value. funct3 100 (byte) and 101 (halfword) zero-extend it. funct3 010 returns the whole word.
- R9: While `halt` is high, the PC, the instruction in execute and the register file stay unchanged. A pending data access keeps `dmem_addr`, `dmem_rd` and `dmem_wr` steady. The memory commits the access in the first cycle in which `halt` is low.
- R10: When every access has one wait state (`halt` high for one cycle, then low for one cycle), the core completes one instruction every two clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Wait request; freezes the core and stretches the current access |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_rd | output | 1 | Load in progress |
| dmem_wr | output | 1 | Store in progress; the memory commits it when `halt` is low |
| dmem_be | output | 4 | Byte enables of a store, bit n for bits 8n+7..8n |
| dmem_wdata | output | 32 | Store data, repeated across byte lanes |
| dmem_rdata | input | 32 | Word at `dmem_addr`, valid in the same cycle |

## Verification
The bench checks the reset slot by putting a store at address 0. A core that executes the stale pipeline register at once would write one cycle too early. Branch tests put a marker write behind every taken branch and jump. A core that failed to flush would leave those markers in the stored registers. The same tests compare a negative operand against a positive one under signed and unsigned compares, and an off-by-one JALR target would skip the stored results. Load and store tests use every lane and both extensions, so a swapped lane or the wrong extension shows up as a wrong memory word. A counting loop run with and without wait states checks the cycle in which its store appears: 9 with no wait states and 18 with one. The final count would come out high if the register file advanced while `halt` was high.

// File: rtl/rvd_pkg.sv
// Package rvd_pkg
// Shared types for the two-stage integer core: the ALU operation codes,
// the write-back source select, the decoded control word and the branch
// condition helper. It assumes 32-bit data and 5-bit register indices.
package rvd_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
    } alu_op_e;

    typedef enum logic [2:0] {
        WB_NONE, WB_ALU, WB_IMM, WB_PCIMM, WB_LINK, WB_LOAD
    } wb_sel_e;

    typedef struct packed {
        alu_op_e          alu_op;
        logic             b_is_imm;
        wb_sel_e          wb;
        logic             is_load;
        logic             is_store;
        logic             is_branch;
        logic             is_jal;
        logic             is_jalr;
        logic [XLEN-1:0]  imm;
        logic [RIDX-1:0]  rd;
        logic [RIDX-1:0]  rs1;
        logic [RIDX-1:0]  rs2;
        logic [2:0]       funct3;
    } ctrl_t;

    // Map funct3 and the alternate bit onto an ALU operation.
    function automatic alu_op_e alu_pick(logic [2:0] f3, logic alt);
        case (f3)
            3'b000:  return alt ? ALU_SUB : ALU_ADD;
            3'b001:  return ALU_SLL;
            3'b010:  return ALU_SLT;
            3'b011:  return ALU_SLTU;
            3'b100:  return ALU_XOR;
            3'b101:  return alt ? ALU_SRA : ALU_SRL;
            3'b110:  return ALU_OR;
            default: return ALU_AND;
        endcase
    endfunction

    // Branch condition by funct3; undefined codes never branch.
    function automatic logic br_cond(logic [2:0] f3, logic [XLEN-1:0] a,
                                     logic [XLEN-1:0] b);
        case (f3)
            3'b000:  return a == b;
            3'b001:  return a != b;
            3'b100:  return $signed(a) < $signed(b);
            3'b101:  return $signed(a) >= $signed(b);
            3'b110:  return a < b;
            3'b111:  return a >= b;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rvd_decode.sv
// Module rvd_decode
// Turns one 32-bit instruction word into the control word used by the
// execute stage. Purely combinational. Unknown opcodes decode to a
// no-operation that writes nothing and touches no memory.
module rvd_decode
    import rvd_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);

    logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;
    logic [6:0]      opc;

    // Immediate formats, all sign-extended from bit 31.
    always_comb begin
        opc   = instr[6:0];
        imm_i = {{20{instr[31]}}, instr[31:20]};
        imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
        imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25],
                 instr[11:8], 1'b0};
        imm_u = {instr[31:12], 12'b0};
        imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20],
                 instr[30:21], 1'b0};
    end

    // Control word by opcode class.
    always_comb begin
        ctrl        = '0;
        ctrl.rd     = instr[11:7];
        ctrl.rs1    = instr[19:15];
        ctrl.rs2    = instr[24:20];
        ctrl.funct3 = instr[14:12];
        ctrl.alu_op = ALU_ADD;
        ctrl.wb     = WB_NONE;
        case (opc)
            OPC_OPIMM: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.imm      = imm_i;
                ctrl.wb       = WB_ALU;
                ctrl.alu_op   = alu_pick(instr[14:12],
                                         instr[30] && (instr[14:12] == 3'b101));
            end
            OPC_OP: begin
                ctrl.wb     = WB_ALU;
                ctrl.alu_op = alu_pick(instr[14:12], instr[30]);
            end
            OPC_LUI: begin
                ctrl.imm = imm_u;
                ctrl.wb  = WB_IMM;
            end
            OPC_AUIPC: begin
                ctrl.imm = imm_u;
                ctrl.wb  = WB_PCIMM;
            end
            OPC_JAL: begin
                ctrl.imm    = imm_j;
                ctrl.wb     = WB_LINK;
                ctrl.is_jal = 1'b1;
            end
            OPC_JALR: begin
                ctrl.imm     = imm_i;
                ctrl.wb      = WB_LINK;
                ctrl.is_jalr = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl.imm       = imm_b;
                ctrl.is_branch = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.imm     = imm_i;
                ctrl.wb      = WB_LOAD;
                ctrl.is_load = 1'b1;
            end
            OPC_STORE: begin
                ctrl.imm      = imm_s;
                ctrl.is_store = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rvd_alu.sv
// Module rvd_alu
// Integer ALU for the ten RV32I operations. Combinational. Shift amounts
// use the low five bits of operand b.
module rvd_alu
    import rvd_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    logic [4:0] sh;

    // Select the result for the requested operation.
    always_comb begin
        sh = b[4:0];
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << sh;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> sh;
            ALU_SRA:  y = $unsigned($signed(a) >>> sh);
            ALU_OR:   y = a | b;
            default:  y = a & b;
        endcase
    end

endmodule

// File: rtl/rvd_regfile.sv
// Module rvd_regfile
// Register file with two combinational read ports and one write port.
// Entry 0 is never written and reads as zero. It assumes the caller
// gates the write enable with the stall condition.
module rvd_regfile #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [DEPTH];

    // Clear on reset; write any entry except zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports with entry zero forced to zero.
    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
    end

endmodule

// File: rtl/rvd_lsu.sv
// Module rvd_lsu
// Byte-lane logic for little-endian data access. On stores it builds the
// byte-enable mask and repeats the data across the lanes. On loads it
// takes the addressed byte or halfword and extends it. Assumes aligned
// accesses.
module rvd_lsu #(
    parameter int LANES = 4
) (
    input  logic [2:0]           funct3,
    input  logic [1:0]           addr_lo,
    input  logic [8*LANES-1:0]   st_data,
    input  logic [8*LANES-1:0]   mem_rdata,
    output logic [LANES-1:0]     be,
    output logic [8*LANES-1:0]   wdata,
    output logic [8*LANES-1:0]   ld_data
);

    localparam int W = 8 * LANES;

    logic [W-1:0] shifted;

    // Store lane mask and data replication.
    always_comb begin
        be    = '0;
        wdata = st_data;
        for (int l = 0; l < LANES; l++) begin
            case (funct3[1:0])
                2'b00: begin
                    wdata[8*l +: 8] = st_data[7:0];
                    be[l]           = (l == int'(addr_lo));
                end
                2'b01: begin
                    wdata[8*l +: 8] = st_data[8*(l%2) +: 8];
                    be[l]           = ((l / 2) == int'(addr_lo[1]));
                end
                default: be[l] = 1'b1;
            endcase
        end
    end

    // Load lane extraction and extension.
    always_comb begin
        shifted = mem_rdata >> {addr_lo, 3'b000};
        case (funct3)
            3'b000:  ld_data = {{(W-8){shifted[7]}}, shifted[7:0]};
            3'b001:  ld_data = {{(W-16){shifted[15]}}, shifted[15:0]};
            3'b100:  ld_data = {{(W-8){1'b0}}, shifted[7:0]};
            3'b101:  ld_data = {{(W-16){1'b0}}, shifted[15:0]};
            default: ld_data = mem_rdata;
        endcase
    end

endmodule

// File: rtl/rv_duo_core.sv
// Module rv_duo_core
// Two-stage RV32I core. Stage one presents the PC on the instruction port.
// Stage two latches the returned word, then decodes, executes, accesses
// data memory and writes back in one clock. A taken branch or jump clears
// the slot fetched behind it. halt freezes every register and holds the
// outstanding requests. Both memories answer reads in the same cycle.
module rv_duo_core
    import rvd_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        halt,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic        dmem_rd,
    output logic        dmem_wr,
    output logic [3:0]  dmem_be,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, ex_pc_q, ex_ir_q;
    logic            ex_valid_q;

    ctrl_t           ctrl;
    logic [XLEN-1:0] rs1_val, rs2_val, alu_b, alu_y, ea, ld_val, st_val;
    logic [XLEN-1:0] wb_val, target;
    logic [3:0]      be_raw;
    logic            take_br, redirect, rf_we;

    rvd_decode u_dec (
        .instr (ex_ir_q),
        .ctrl  (ctrl)
    );

    rvd_regfile #(.ADDR_W(RIDX), .DATA_W(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (ctrl.rd),
        .wdata   (wb_val),
        .raddr_a (ctrl.rs1),
        .raddr_b (ctrl.rs2),
        .rdata_a (rs1_val),
        .rdata_b (rs2_val)
    );

    rvd_alu u_alu (
        .op (ctrl.alu_op),
        .a  (rs1_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    rvd_lsu #(.LANES(XLEN / 8)) u_lsu (
        .funct3    (ctrl.funct3),
        .addr_lo   (ea[1:0]),
        .st_data   (rs2_val),
        .mem_rdata (dmem_rdata),
        .be        (be_raw),
        .wdata     (st_val),
        .ld_data   (ld_val)
    );

    // Operand select, effective address and control-flow decision.
    always_comb begin
        alu_b    = ctrl.b_is_imm ? ctrl.imm : rs2_val;
        ea       = rs1_val + ctrl.imm;
        take_br  = ctrl.is_branch && br_cond(ctrl.funct3, rs1_val, rs2_val);
        redirect = ex_valid_q && (take_br || ctrl.is_jal || ctrl.is_jalr);
        target   = ctrl.is_jalr ? {ea[XLEN-1:1], 1'b0} : (ex_pc_q + ctrl.imm);
    end

    // Write-back source select and enable.
    always_comb begin
        case (ctrl.wb)
            WB_ALU:   wb_val = alu_y;
            WB_IMM:   wb_val = ctrl.imm;
            WB_PCIMM: wb_val = ex_pc_q + ctrl.imm;
            WB_LINK:  wb_val = ex_pc_q + STEP;
            WB_LOAD:  wb_val = ld_val;
            default:  wb_val = '0;
        endcase
        rf_we = ex_valid_q && !halt && (ctrl.wb != WB_NONE);
    end

    // Port drive; requests stay up for as long as halt stretches them.
    always_comb begin
        imem_addr  = pc_q;
        dmem_addr  = ea;
        dmem_rd    = ex_valid_q && ctrl.is_load;
        dmem_wr    = ex_valid_q && ctrl.is_store;
        dmem_be    = dmem_wr ? be_raw : 4'b0000;
        dmem_wdata = st_val;
    end

    // Fetch/execute pipeline register and program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= RESET_PC;
            ex_pc_q    <= '0;
            ex_ir_q    <= '0;
            ex_valid_q <= 1'b0;
        end else if (!halt) begin
            ex_ir_q <= imem_rdata;
            ex_pc_q <= pc_q;
            if (redirect) begin
                pc_q       <= target;
                ex_valid_q <= 1'b0;
            end else begin
                pc_q       <= pc_q + STEP;
                ex_valid_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rvd_checker.sv
// Module rvd_checker
// Protocol and pipeline properties of rv_duo_core, attached with bind.
// It observes the ports and the internal redirect decision only.
module rvd_checker #(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        halt,
    input logic [31:0] imem_addr,
    input logic [31:0] dmem_addr,
    input logic        dmem_rd,
    input logic        dmem_wr,
    input logic [3:0]  dmem_be,
    input logic        redirect
);

    // A cycle in reset leads to a fetch from the reset address and a bubble.
    p_reset_slot_r1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == RESET_PC) && !dmem_rd && !dmem_wr);

    // Sequential fetch advances by one word per free cycle.
    p_seq_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && !redirect) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // The slot behind a taken control transfer makes no data access.
    p_flush_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !halt) |=> (!dmem_rd && !dmem_wr));

    // halt freezes the fetch address.
    p_halt_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(imem_addr));

    // A stretched data access keeps its request steady.
    p_halt_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && (dmem_rd || dmem_wr)) |=>
            ($stable(dmem_addr) && $stable(dmem_rd) && $stable(dmem_wr)));

    // Store lane masks are one byte, an aligned half or the full word.
    p_be_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_wr |-> (dmem_be == 4'b0001 || dmem_be == 4'b0010 ||
                     dmem_be == 4'b0100 || dmem_be == 4'b1000 ||
                     dmem_be == 4'b0011 || dmem_be == 4'b1100 ||
                     dmem_be == 4'b1111));

    // A single instruction never loads and stores at once.
    p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_rd && dmem_wr));

endmodule

bind rv_duo_core rvd_checker #(.RESET_PC(RESET_PC)) u_rvd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .imem_addr (imem_addr),
    .dmem_addr (dmem_addr),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr),
    .dmem_be   (dmem_be),
    .redirect  (redirect)
);

// File: tb/rv_duo_core_bench.sv
// Directed bench for rv_duo_core. The memories are arrays. Reads return
// data in the same cycle, and writes commit on the clock edge when halt
// is low. Each task loads a small program and checks what it leaves in
// data memory or on the ports.
module rv_duo_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd, dmem_wr;
    logic [3:0]  dmem_be;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rv_duo_core u_rv_duo_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (halt),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rd    (dmem_rd),
        .dmem_wr    (dmem_wr),
        .dmem_be    (dmem_be),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    // Data memory write port, committing only in cycles without a wait state.
    always @(posedge clk) begin
        if (dmem_wr && !halt) begin
            for (int l = 0; l < 4; l++)
                if (dmem_be[l]) dmem[dmem_addr[9:2]][8*l +: 8] <= dmem_wdata[8*l +: 8];
        end
    end

    // Instruction encoders.
    function automatic logic [31:0] e_i(int imm, int rs1, int f3, int rd, int op);
        return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), 7'(op)};
    endfunction
    function automatic logic [31:0] e_r(int f7, int rs2, int rs1, int f3, int rd);
        return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'h33};
    endfunction
    function automatic logic [31:0] e_s(int imm, int rs2, int rs1, int f3);
        logic [31:0] m = imm;
        return {m[11:5], 5'(rs2), 5'(rs1), 3'(f3), m[4:0], 7'h23};
    endfunction
    function automatic logic [31:0] e_b(int imm, int rs2, int rs1, int f3);
        logic [31:0] m = imm;
        return {m[12], m[10:5], 5'(rs2), 5'(rs1), 3'(f3), m[4:1], m[11], 7'h63};
    endfunction
    function automatic logic [31:0] e_u(int imm20, int rd, int op);
        return {20'(imm20), 5'(rd), 7'(op)};
    endfunction
    function automatic logic [31:0] e_j(int imm, int rd);
        logic [31:0] m = imm;
        return {m[20], m[10:1], m[11], m[19:12], 5'(rd), 7'h6F};
    endfunction
    function automatic logic [31:0] addi(int rd, int rs1, int imm);
        return e_i(imm, rs1, 0, rd, 8'h13);
    endfunction
    function automatic logic [31:0] sw(int rs2, int off);
        return e_s(off, rs2, 0, 2);
    endfunction

    // Compare one value and log a failure line.
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Fill instruction memory with self-loops and clear data memory.
    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = e_j(0, 0);
            dmem[i] = 32'h0;
        end
    endtask

    // Hold reset for three clocks and release it at a falling edge.
    task automatic do_reset();
        halt  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset address and the bubble slot before the first instruction.
    task automatic t_reset();
        clear_mem();
        imem[0] = sw(0, 64);
        halt  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 fetch address in reset", imem_addr, 32'h0);
        rst_n = 1'b1;
        #1;
        chk("R1 first slot after reset is a bubble", {31'b0, dmem_wr}, 32'h0);
        @(negedge clk);
        chk("R1 store at reset address runs in second cycle", {31'b0, dmem_wr}, 32'h1);
        chk("R3 fetch advanced by one word", imem_addr, 32'h4);
    endtask

    // R5, R3: arithmetic, logic, shifts, upper immediates, back-to-back use.
    task automatic t_alu();
        logic [31:0] exp [12];
        clear_mem();
        imem[0]  = addi(1, 0, 5);
        imem[1]  = addi(2, 0, -3);
        imem[2]  = e_r(0, 2, 1, 0, 3);
        imem[3]  = e_r(32, 2, 1, 0, 4);
        imem[4]  = e_r(0, 1, 2, 2, 5);
        imem[5]  = e_r(0, 1, 2, 3, 6);
        imem[6]  = e_i(255, 1, 4, 7, 8'h13);
        imem[7]  = e_i(4, 2, 1, 8, 8'h13);
        imem[8]  = e_i(1025, 2, 5, 9, 8'h13);
        imem[9]  = e_i(28, 2, 5, 10, 8'h13);
        imem[10] = e_u(32'h12345, 11, 8'h37);
        imem[11] = e_u(1, 12, 8'h17);
        imem[12] = e_r(0, 2, 1, 6, 13);
        imem[13] = e_r(0, 2, 1, 7, 14);
        for (int k = 0; k < 12; k++) imem[14 + k] = sw(3 + k, 4 * k);
        exp = '{32'h2, 32'h8, 32'h1, 32'h0, 32'hFA, 32'hFFFFFFD0, 32'hFFFFFFFE,
                32'hF, 32'h12345000, 32'h102C, 32'hFFFFFFFD, 32'h5};
        do_reset();
        run(40);
        for (int k = 0; k < 12; k++)
            chk($sformatf("R5 alu result %0d (R3 dependent use)", k), dmem[k], exp[k]);
    endtask

    // R2: x0 ignores writes and reads as zero.
    task automatic t_zero();
        clear_mem();
        dmem[0] = 32'hDEADBEEF;
        imem[0] = addi(0, 0, 7);
        imem[1] = sw(0, 0);
        imem[2] = addi(3, 0, 1);
        imem[3] = sw(3, 4);
        do_reset();
        run(10);
        chk("R2 x0 after write attempt", dmem[0], 32'h0);
        chk("R2 x0 as source operand", dmem[1], 32'h1);
    endtask

    // R4, R6: flush behind taken transfers, signed and unsigned compares, links.
    task automatic t_branch();
        clear_mem();
        imem[0]  = addi(1, 0, -1);
        imem[1]  = addi(2, 0, 2);
        imem[2]  = e_b(8, 2, 1, 0);
        imem[3]  = e_b(8, 2, 1, 4);
        imem[4]  = addi(3, 0, 99);
        imem[5]  = e_b(8, 1, 1, 1);
        imem[6]  = e_b(8, 2, 1, 7);
        imem[7]  = addi(4, 0, 99);
        imem[8]  = e_j(8, 5);
        imem[9]  = addi(6, 0, 99);
        imem[10] = addi(7, 0, 53);
        imem[11] = e_i(0, 7, 0, 8, 8'h67);
        imem[12] = addi(9, 0, 99);
        imem[13] = sw(3, 0);
        imem[14] = sw(4, 4);
        imem[15] = sw(5, 8);
        imem[16] = sw(6, 12);
        imem[17] = sw(8, 16);
        imem[18] = sw(9, 20);
        do_reset();
        run(40);
        chk("R4 slot behind signed taken branch flushed", dmem[0], 32'h0);
        chk("R4 slot behind unsigned taken branch flushed", dmem[1], 32'h0);
        chk("R6 JAL link value", dmem[2], 32'd36);
        chk("R4 slot behind JAL flushed", dmem[3], 32'h0);
        chk("R6 JALR link value", dmem[4], 32'd48);
        chk("R6 JALR target bit 0 cleared, slot flushed", dmem[5], 32'h0);
    endtask

    // R7, R8: byte lanes, extensions and partial stores.
    task automatic t_lanes();
        clear_mem();
        dmem[0] = 32'h80F17F02;
        dmem[8] = 32'h11223344;
        dmem[9] = 32'h11223344;
        imem[0] = e_i(3, 0, 0, 1, 8'h03);
        imem[1] = e_i(2, 0, 4, 2, 8'h03);
        imem[2] = e_i(1, 0, 0, 3, 8'h03);
        imem[3] = e_i(2, 0, 1, 4, 8'h03);
        imem[4] = e_i(2, 0, 5, 5, 8'h03);
        imem[5] = e_i(0, 0, 2, 6, 8'h03);
        imem[6] = addi(7, 0, 171);
        imem[7] = e_s(33, 7, 0, 0);
        imem[8] = e_s(38, 7, 0, 1);
        for (int k = 0; k < 6; k++) imem[9 + k] = sw(1 + k, 64 + 4 * k);
        do_reset();
        run(30);
        chk("R8 LB lane 3 sign-extended", dmem[16], 32'hFFFFFF80);
        chk("R8 LBU lane 2 zero-extended", dmem[17], 32'h000000F1);
        chk("R8 LB lane 1 positive", dmem[18], 32'h0000007F);
        chk("R8 LH upper half sign-extended", dmem[19], 32'hFFFF80F1);
        chk("R8 LHU upper half zero-extended", dmem[20], 32'h000080F1);
        chk("R8 LW whole word", dmem[21], 32'h80F17F02);
        chk("R7 SB into lane 1 only", dmem[8], 32'h1122AB44);
        chk("R7 SH into upper half only", dmem[9], 32'h00AB3344);
    endtask

    // R3, R9, R10: counting loop with and without one wait state per access.
    task automatic t_wait(bit one_wait);
        int cnt;
        int seen;
        logic [31:0] held;
        clear_mem();
        for (int k = 0; k < 8; k++) imem[k] = addi(1, 1, 1);
        imem[8] = sw(1, 128);
        halt  = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        halt  = one_wait;
        cnt  = 0;
        seen = -1;
        held = '0;
        while (cnt < 60) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
            if (seen < 0 && dmem_wr) begin
                seen = cnt;
                held = imem_addr;
            end else if (seen >= 0 && cnt == seen + 1 && one_wait) begin
                chk("R9 fetch address frozen during wait state", imem_addr, held);
            end
            halt = one_wait ? (cnt % 2 == 0) : 1'b0;
        end
        halt = 1'b0;
        if (one_wait) begin
            chk("R10 store cycle with one wait state", seen, 32'd18);
            chk("R9 register file frozen during wait states", dmem[32], 32'd8);
        end else begin
            chk("R3 store cycle with no wait state", seen, 32'd9);
            chk("R3 count with no wait state", dmem[32], 32'd8);
        end
    endtask

    // Watchdog: a hung run ends as a failure with the summary.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_zero();
        t_branch();
        t_lanes();
        t_wait(1'b0);
        t_wait(1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule